// File: doc/BRIEF.md
# Rename Register File Occupancy Tracker

This block counts how many physical registers are in use in each of several rename register files while register renaming is under way. A programmable map table gives each logical destination register an owning file and a cost, the number of physical registers one definition of it consumes. Rename sends one allocate per cycle and retirement sends one free per cycle. Each request names a logical register and carries flags that say whether the write really consumes storage. File 0 is a global file that is charged for every counted allocation and free. A register owned by a nonzero file charges that file as well.

Before rename commits a group of up to four destinations, it asks whether the group fits. The block sums the group's costs per file and returns a stall bitmask with one bit per file. A file configured with size zero has no limit. A group that is larger than a whole file is clamped to that file's size, so it can never stall forever. If a counter would go below zero, it stops at zero and a sticky error bit is raised.

Top module: `phys_reg_occupancy`

## Requirements
- R1: An allocate whose flags are all zero adds the map entry's cost to file 0. If the owning file index is nonzero, it also adds the cost to that file.
- R2: A free whose flags are all zero subtracts the map entry's cost from file 0. If the owning file index is nonzero, it also subtracts the cost from that file.
- R3: Request flag bit 0 marks a zero idiom, bit 1 an eliminated move, and bit 2 a partial write merged with its super-register that does not clear the upper part. An allocate or free with any of these bits set leaves every counter unchanged.
- R4: When an allocate and a free arrive in the same cycle, each counter moves by the net difference one cycle later.
- R5: If a free would take a counter below zero, that counter becomes 0 and `underflow_err` goes to 1. It stays at 1 until reset.
- R6: Stall bit i is 1 when file i's used count plus the group's summed cost for file i, after clamping, exceeds file i's size.
- R7: A file whose configured size is 0 never sets its stall bit.
- R8: If a group's summed cost for a file exceeds that file's size, the sum is replaced by the size before the comparison.
- R9: After reset, every map entry is file 0 with cost 1. A write on the configuration port replaces one entry from the next cycle on.
- R10: Reset clears all used counters and `underflow_err`.
- R11: Query slots whose valid bit is 0 add no cost. A file with zero demand from the group never sets its stall bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Map table write enable |
| cfg_lreg | input | 6 | Logical register being written |
| cfg_file | input | 2 | Owning file index for the entry |
| cfg_cost | input | 3 | Cost for the entry |
| alloc_valid | input | 1 | Allocate request |
| alloc_lreg | input | 6 | Logical register being allocated |
| alloc_flags | input | 3 | Allocate flags (bit 0 zero idiom, bit 1 eliminated move, bit 2 merged partial write) |
| free_valid | input | 1 | Free request |
| free_lreg | input | 6 | Logical register being freed |
| free_flags | input | 3 | Free flags, same encoding as the allocate flags |
| query_valid | input | 4 | Per-slot valid bits for the availability query |
| query_lregs | input | 24 | Slot s destination in bits [6s+5:6s] |
| stall_mask | output | 4 | Per-file stall bits, combinational from the query |
| used_counts | output | 32 | File f used count in bits [8f+7:8f] |
| underflow_err | output | 1 | Sticky underflow flag |

## Verification
Every cycle, the assertions check four things. The map table takes each configuration write. The counters hold still when no charge arrives. A counter that underflows lands at zero with the error bit set, and the error bit never drops before reset. On the query side, the assertions check that a full file with nonzero demand stalls and that a file with no demand never stalls. Only the bench scenarios can show the per-file charging arithmetic for specific map contents. The same holds for the net result of combined allocate and free, the clamp on an oversized group, and the unbounded file's silence, because each of these depends on chosen sizes and costs.

// File: rtl/rot_pkg.sv
package rot_pkg;
    localparam int FILES  = 4;
    localparam int LREGS  = 64;
    localparam int CNT_W  = 8;
    localparam int COST_W = 3;
    localparam int QSLOTS = 4;
    localparam int FLAG_W = 3;

    localparam int FID_W = $clog2(FILES);
    localparam int LID_W = $clog2(LREGS);
    localparam int SUM_W = COST_W + $clog2(QSLOTS) + 1;
    localparam int NRD   = QSLOTS + 2;

    typedef struct packed {
        logic [FID_W-1:0]  file;
        logic [COST_W-1:0] cost;
    } map_t;

    typedef logic [FILES-1:0][SUM_W-1:0] fsum_t;
    typedef logic [FILES-1:0][CNT_W-1:0] fcnt_t;

    function automatic fsum_t charge(map_t e, logic en);
        fsum_t r;
        r = '0;
        if (en) begin
            r[0] = SUM_W'(e.cost);
            if (e.file != '0) r[e.file] = SUM_W'(e.cost);
        end
        return r;
    endfunction
endpackage

// File: rtl/rot_map_table.sv
module rot_map_table
    import rot_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [LID_W-1:0]          wr_lreg,
    input  map_t                      wr_ent,
    input  logic [NRD-1:0][LID_W-1:0] rd_lreg,
    output map_t [NRD-1:0]            rd_ent
);
    localparam map_t RESET_ENT = '{file: '0, cost: COST_W'(1)};

    typedef struct packed {
        map_t [LREGS-1:0] ent;
    } tbl_st_t;

    tbl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ent[wr_lreg] = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.ent <= {LREGS{RESET_ENT}};
        else        s_q <= s_d;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_ent[r] = s_q.ent[rd_lreg[r]];
    end

    // R9: a configuration write is visible on the next cycle
    p_cfg_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.ent[$past(wr_lreg)] == $past(wr_ent));
endmodule

// File: rtl/rot_counters.sv
module rot_counters
    import rot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  fsum_t add,
    input  fsum_t sub,
    output fcnt_t used,
    output logic  err
);
    localparam int WW = CNT_W + SUM_W + 1;
    localparam logic [WW-1:0] CNT_MAX = WW'({CNT_W{1'b1}});

    typedef struct packed {
        fcnt_t used;
        logic  err;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        logic [WW-1:0] gross;
        logic [WW-1:0] net;
        s_d = s_q;
        for (int f = 0; f < FILES; f++) begin
            gross = WW'(s_q.used[f]) + WW'(add[f]);
            net   = gross - WW'(sub[f]);
            if (gross < WW'(sub[f])) begin
                s_d.used[f] = '0;
                s_d.err     = 1'b1;
            end else if (net > CNT_MAX) begin
                s_d.used[f] = '1;
            end else begin
                s_d.used[f] = CNT_W'(net);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign used = s_q.used;
    assign err  = s_q.err;

    // R3: with no charge arriving the counters stay put
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (add == '0 && sub == '0) |=> $stable(used));

    // R5: the error flag is sticky
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    for (genvar f = 0; f < FILES; f++) begin : g_chk
        // R5: an underflowing counter lands on zero and flags the error
        p_underflow_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (WW'(used[f]) + WW'(add[f]) < WW'(sub[f])) |=> (used[f] == '0 && err));
    end
endmodule

// File: rtl/rot_stall_check.sv
module rot_stall_check
    import rot_pkg::*;
#(
    parameter logic [FILES*CNT_W-1:0] FILE_SIZES = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fsum_t            demand,
    input  fcnt_t            used,
    output logic [FILES-1:0] stall
);
    localparam int WW = CNT_W + SUM_W + 1;

    for (genvar f = 0; f < FILES; f++) begin : g_file
        localparam logic [CNT_W-1:0] SZ = FILE_SIZES[f*CNT_W +: CNT_W];
        logic [WW-1:0] req;

        assign req = (WW'(demand[f]) > WW'(SZ)) ? WW'(SZ) : WW'(demand[f]);
        assign stall[f] = (SZ != '0) && (demand[f] != '0) &&
                          (WW'(used[f]) + req > WW'(SZ));

        // R11: no demand on a file means no stall bit for it
        p_no_demand_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (demand[f] == '0) |-> !stall[f]);

        if (SZ != '0) begin : g_bounded
            // R6: a full bounded file stalls any nonzero demand
            p_full_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (demand[f] != '0 && used[f] >= SZ) |-> stall[f]);
        end
    end
endmodule

// File: rtl/phys_reg_occupancy.sv
module phys_reg_occupancy
    import rot_pkg::*;
#(
    parameter logic [FILES*CNT_W-1:0] FILE_SIZES = {8'd8, 8'd0, 8'd16, 8'd40}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [LID_W-1:0]        cfg_lreg,
    input  logic [FID_W-1:0]        cfg_file,
    input  logic [COST_W-1:0]       cfg_cost,
    input  logic                    alloc_valid,
    input  logic [LID_W-1:0]        alloc_lreg,
    input  logic [FLAG_W-1:0]       alloc_flags,
    input  logic                    free_valid,
    input  logic [LID_W-1:0]        free_lreg,
    input  logic [FLAG_W-1:0]       free_flags,
    input  logic [QSLOTS-1:0]       query_valid,
    input  logic [QSLOTS*LID_W-1:0] query_lregs,
    output logic [FILES-1:0]        stall_mask,
    output logic [FILES*CNT_W-1:0]  used_counts,
    output logic                    underflow_err
);
    logic [NRD-1:0][LID_W-1:0] rd_lreg;
    map_t [NRD-1:0]            rd_ent;
    fsum_t                     add_chg, sub_chg, q_demand;
    fcnt_t                     used;

    assign rd_lreg[0] = alloc_lreg;
    assign rd_lreg[1] = free_lreg;
    for (genvar s = 0; s < QSLOTS; s++) begin : g_qaddr
        assign rd_lreg[2+s] = query_lregs[s*LID_W +: LID_W];
    end

    rot_map_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_lreg (cfg_lreg),
        .wr_ent  ('{file: cfg_file, cost: cfg_cost}),
        .rd_lreg (rd_lreg),
        .rd_ent  (rd_ent)
    );

    always_comb begin
        fsum_t one;
        add_chg  = charge(rd_ent[0], alloc_valid && (alloc_flags == '0));
        sub_chg  = charge(rd_ent[1], free_valid && (free_flags == '0));
        q_demand = '0;
        for (int s = 0; s < QSLOTS; s++) begin
            one = charge(rd_ent[2+s], query_valid[s]);
            for (int f = 0; f < FILES; f++) q_demand[f] = q_demand[f] + one[f];
        end
    end

    rot_counters u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (add_chg),
        .sub   (sub_chg),
        .used  (used),
        .err   (underflow_err)
    );

    rot_stall_check #(.FILE_SIZES(FILE_SIZES)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .demand (q_demand),
        .used   (used),
        .stall  (stall_mask)
    );

    assign used_counts = used;
endmodule

// File: tb/test_phys_reg_occupancy.sv
module test_phys_reg_occupancy;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_lreg = '0;
    logic [1:0]  cfg_file = '0;
    logic [2:0]  cfg_cost = '0;
    logic        alloc_valid = 1'b0;
    logic [5:0]  alloc_lreg = '0;
    logic [2:0]  alloc_flags = '0;
    logic        free_valid = 1'b0;
    logic [5:0]  free_lreg = '0;
    logic [2:0]  free_flags = '0;
    logic [3:0]  query_valid = '0;
    logic [23:0] query_lregs = '0;
    logic [3:0]  stall_mask;
    logic [31:0] used_counts;
    logic        underflow_err;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    phys_reg_occupancy #(.FILE_SIZES({8'd8, 8'd0, 8'd16, 8'd40})) i_phys_reg_occupancy (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_lreg(cfg_lreg), .cfg_file(cfg_file), .cfg_cost(cfg_cost),
        .alloc_valid(alloc_valid), .alloc_lreg(alloc_lreg), .alloc_flags(alloc_flags),
        .free_valid(free_valid), .free_lreg(free_lreg), .free_flags(free_flags),
        .query_valid(query_valid), .query_lregs(query_lregs),
        .stall_mask(stall_mask), .used_counts(used_counts), .underflow_err(underflow_err)
    );

    typedef struct packed {
        logic       av; logic [5:0] al; logic [2:0] af;
        logic       fv; logic [5:0] fl; logic [2:0] ff;
        logic [7:0] e0; logic [7:0] e1; logic [7:0] e2; logic [7:0] e3;
    } vec_t;

    // map: l1 f1c1, l2 f1c2, l3 f2c3, l4 f3c4, l5 f3c7, l0 default f0c1
    localparam vec_t VEC [13] = '{
        '{1'b1, 6'd1, 3'd0, 1'b0, 6'd0, 3'd0,  8'd1, 8'd1, 8'd0, 8'd0},  // R1
        '{1'b1, 6'd2, 3'd0, 1'b0, 6'd0, 3'd0,  8'd3, 8'd3, 8'd0, 8'd0},  // R1
        '{1'b1, 6'd3, 3'd0, 1'b0, 6'd0, 3'd0,  8'd6, 8'd3, 8'd3, 8'd0},  // R1
        '{1'b1, 6'd4, 3'd0, 1'b0, 6'd0, 3'd0, 8'd10, 8'd3, 8'd3, 8'd4},  // R1
        '{1'b1, 6'd0, 3'd0, 1'b0, 6'd0, 3'd0, 8'd11, 8'd3, 8'd3, 8'd4},  // R1
        '{1'b1, 6'd5, 3'd1, 1'b0, 6'd0, 3'd0, 8'd11, 8'd3, 8'd3, 8'd4},  // R3
        '{1'b1, 6'd5, 3'd2, 1'b0, 6'd0, 3'd0, 8'd11, 8'd3, 8'd3, 8'd4},  // R3
        '{1'b1, 6'd2, 3'd4, 1'b0, 6'd0, 3'd0, 8'd11, 8'd3, 8'd3, 8'd4},  // R3
        '{1'b0, 6'd0, 3'd0, 1'b1, 6'd2, 3'd0,  8'd9, 8'd1, 8'd3, 8'd4},  // R2
        '{1'b1, 6'd2, 3'd0, 1'b1, 6'd1, 3'd0, 8'd10, 8'd2, 8'd3, 8'd4},  // R4
        '{1'b0, 6'd0, 3'd0, 1'b1, 6'd3, 3'd1, 8'd10, 8'd2, 8'd3, 8'd4},  // R3
        '{1'b0, 6'd0, 3'd0, 1'b1, 6'd3, 3'd0,  8'd7, 8'd2, 8'd0, 8'd4},  // R2
        '{1'b1, 6'd4, 3'd0, 1'b1, 6'd4, 3'd0,  8'd7, 8'd2, 8'd0, 8'd4}   // R4
    };

    task automatic check_counts(string req, logic [7:0] e0, logic [7:0] e1,
                                logic [7:0] e2, logic [7:0] e3);
        logic [31:0] exp_v;
        exp_v = {e3, e2, e1, e0};
        n_tests++;
        if (used_counts !== exp_v) begin
            n_fail++;
            $display("FAIL %s used_counts actual=%h expected=%h", req, used_counts, exp_v);
        end
    endtask

    task automatic check_err(string req, logic e);
        n_tests++;
        if (underflow_err !== e) begin
            n_fail++;
            $display("FAIL %s underflow_err actual=%b expected=%b", req, underflow_err, e);
        end
    endtask

    task automatic check_query(string req, logic [3:0] qv, logic [23:0] ql, logic [3:0] e);
        query_valid = qv;
        query_lregs = ql;
        #1;
        n_tests++;
        if (stall_mask !== e) begin
            n_fail++;
            $display("FAIL %s stall_mask actual=%b expected=%b", req, stall_mask, e);
        end
        query_valid = '0;
    endtask

    task automatic do_op(logic av, logic [5:0] al, logic [2:0] af,
                         logic fv, logic [5:0] fl, logic [2:0] ff);
        alloc_valid = av; alloc_lreg = al; alloc_flags = af;
        free_valid = fv;  free_lreg = fl;  free_flags = ff;
        @(negedge clk);
        alloc_valid = 1'b0; free_valid = 1'b0;
        alloc_flags = '0;   free_flags = '0;
    endtask

    task automatic do_cfg(logic [5:0] l, logic [1:0] f, logic [2:0] c);
        cfg_we = 1'b1; cfg_lreg = l; cfg_file = f; cfg_cost = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        check_counts("R10", 8'd0, 8'd0, 8'd0, 8'd0);
        check_err("R10", 1'b0);
        check_query("R11", 4'b0001, 24'd0, 4'b0000);

        // R9: unconfigured entry defaults to file 0 cost 1
        do_op(1'b1, 6'd10, 3'd0, 1'b0, 6'd0, 3'd0);
        check_counts("R9", 8'd1, 8'd0, 8'd0, 8'd0);
        do_op(1'b0, 6'd0, 3'd0, 1'b1, 6'd10, 3'd0);
        check_counts("R9", 8'd0, 8'd0, 8'd0, 8'd0);

        do_cfg(6'd1, 2'd1, 3'd1);
        do_cfg(6'd2, 2'd1, 3'd2);
        do_cfg(6'd3, 2'd2, 3'd3);
        do_cfg(6'd4, 2'd3, 3'd4);
        do_cfg(6'd5, 2'd3, 3'd7);

        for (int i = 0; i < 13; i++) begin
            do_op(VEC[i].av, VEC[i].al, VEC[i].af, VEC[i].fv, VEC[i].fl, VEC[i].ff);
            check_counts($sformatf("R1/R2/R3/R4 vec%0d", i),
                         VEC[i].e0, VEC[i].e1, VEC[i].e2, VEC[i].e3);
        end
        check_err("R5 none", 1'b0);

        // state 7,2,0,4
        check_query("R6 fits", 4'b0001, {18'd0, 6'd4}, 4'b0000);
        check_query("R6 over", 4'b0001, {18'd0, 6'd5}, 4'b1000);

        do_op(1'b0, 6'd0, 3'd0, 1'b1, 6'd4, 3'd0);
        check_counts("R2", 8'd3, 8'd2, 8'd0, 8'd0);
        check_query("R8 clamp", 4'b0011, {12'd0, 6'd5, 6'd5}, 4'b0000);
        check_query("R7 unbounded", 4'b1111, {6'd3, 6'd3, 6'd3, 6'd3}, 4'b0000);

        do_op(1'b1, 6'd4, 3'd0, 1'b0, 6'd0, 3'd0);
        check_counts("R1", 8'd7, 8'd2, 8'd0, 8'd4);
        check_query("R11 masked", 4'b0001, {12'd0, 6'd5, 6'd4}, 4'b0000);
        check_query("R6 R8 both", 4'b0011, {12'd0, 6'd5, 6'd4}, 4'b1000);

        // R5: free cost 7 from file 3 holding 4
        do_op(1'b0, 6'd0, 3'd0, 1'b1, 6'd5, 3'd0);
        check_counts("R5", 8'd0, 8'd2, 8'd0, 8'd0);
        check_err("R5", 1'b1);
        do_op(1'b1, 6'd1, 3'd0, 1'b0, 6'd0, 3'd0);
        check_counts("R5", 8'd1, 8'd3, 8'd0, 8'd0);
        check_err("R5 sticky", 1'b1);

        do_reset();
        check_counts("R10", 8'd0, 8'd0, 8'd0, 8'd0);
        check_err("R10", 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule